// File: doc/BRIEF.md
# Voltage-Triggered Four-Rail Power Sequencer

This block controls four supply rails in a system where each rail may only come up once its own input voltage is good. While the active-low enable is asserted, every channel drives its gate enable on as soon as its own synchronized rail-good flag is true, with no timer and no dependence on the other channels. A chained, voltage-ordered power-up results when the output of one rail is wired to the good flag of the next.

When all four gates report that they are fully on, a hold timer runs. After it expires, the active-low load reset is released. A rail-good flag that later drops pulls the load reset low again, but no gate is switched off because of it. Releasing the enable pulls the load reset low at once and starts a timed power-down. In that power-down each gate drops after its own off-delay count. The power-down always runs to the end. A new power-up is accepted only when every gate is off and the enable has been seen inactive and then active again.

Top module: `rail_seq_top`

## Requirements
- R1: In the run state, channel i's `gate_on[i]` sets on the third rising edge after `rail_ok[i]` goes high. The first two edges are the two-flop synchronizer and the third is the gate register. The other channels have no effect on this.
- R2: `rail_rst_n` goes high after HOLD_CYCLES consecutive rising edges at which the enable is active and all four `gate_full` and all four synchronized rail-good flags are 1.
- R3: If a rail-good input goes low while running, `rail_rst_n` goes low on the third edge after the change. Every `gate_on` bit that is set remains set.
- R4: Driving `en_n` high while running makes `rail_rst_n` low after the next edge, which is the entry edge. `gate_on[i]` clears on the edge numbered `off_dly[i]`+1 after the entry edge. `off_dly` holds channel i in bits [i*OFF_W +: OFF_W].
- R5: If any `gate_full` bit drops before the hold timer expires, the count restarts from zero. It needs a full HOLD_CYCLES edges again.
- R6: Once the power-down has begun, changes on `rail_ok` or `en_n` neither alter nor stop the timed sequence.
- R7: After a power-down, no gate turns on again until all gates are off, `en_n` has been high, and `en_n` is then driven low. The gates are set again one edge after the run state is entered.
- R8: While `arst_n` is low, all `gate_on` bits are 0 and `rail_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| en_n | input | 1 | Active-low sequencing enable |
| rail_ok | input | N_CH | Per-rail undervoltage-good flags (asynchronous) |
| gate_full | input | N_CH | Per-rail gate-fully-on flags |
| off_dly | input | N_CH*OFF_W | Per-channel power-down delay counts |
| gate_on | output | N_CH | Per-rail gate enables |
| rail_rst_n | output | 1 | Active-low load reset |

## Verification
The bench builds the block with HOLD_CYCLES = 20 in place of the default of 15,000,000, which corresponds to 150 ms at 100 MHz. With this value the release edge, and a restart of the count partway through, can both be checked cycle-exactly. The off-delay width stays at 8 bits. Distinct delays of 0, 2, 5 and 8 make the four gates drop on separate edges in a non-index order. They also cover the zero-delay case and leave room to toggle the inputs in the middle of the power-down.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_SHUT = 2'd2,
    SQ_PARK = 2'd3
  } sq_state_t;

  // saturating hold count: cleared when the condition is absent
  function automatic logic [31:0] hold_next(input logic [31:0] cur,
                                            input logic cond,
                                            input logic [31:0] limit);
    if (!cond) return 32'd0;
    if (cur == limit) return cur;
    return cur + 32'd1;
  endfunction

  // power-down delay count step
  function automatic logic [31:0] off_step(input logic [31:0] cur);
    return (cur == 32'd0) ? 32'd0 : cur - 32'd1;
  endfunction
endpackage

// File: rtl/rail_seq_sync2.sv
module rail_seq_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/rail_seq_hold.sv
module rail_seq_hold
  import rail_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 15_000_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [31:0] LIMIT = 32'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [31:0]   cnt_nx;

  assign cnt_nx = hold_next(32'(cnt_q), cond, LIMIT);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_nx[CW-1:0];
  end

  assign done = (32'(cnt_q) == LIMIT);

  AST_DONE_AFTER_COND: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> $past(cond)); // R2
  AST_RESTART_ON_LOSS: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(cond) |-> !done); // R5
endmodule

// File: rtl/rail_seq_chan.sv
module rail_seq_chan
  import rail_seq_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             on_req,
  input  logic             load,
  input  logic             in_shut,
  input  logic [OFF_W-1:0] dly,
  output logic             gate
);
  logic [OFF_W-1:0] cnt_q;
  logic [31:0]      cnt_dec;
  logic             expired;

  assign cnt_dec = off_step(32'(cnt_q));
  assign expired = in_shut && (cnt_q == '0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt_q <= '0;
    else if (load)    cnt_q <= dly;
    else if (in_shut) cnt_q <= cnt_dec[OFF_W-1:0];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      gate <= 1'b0;
    else if (on_req)  gate <= 1'b1;
    else if (expired) gate <= 1'b0;
  end

  AST_DROP_ON_EXPIRY: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(gate) |-> $past(in_shut) && $past(cnt_q == '0)); // R4
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(gate) |-> $past(on_req)); // R1
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int          N_CH        = 4,
  parameter int          OFF_W       = 8,
  parameter int unsigned HOLD_CYCLES = 15_000_000
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  en_n,
  input  logic [N_CH-1:0]       rail_ok,
  input  logic [N_CH-1:0]       gate_full,
  input  logic [N_CH*OFF_W-1:0] off_dly,
  output logic [N_CH-1:0]       gate_on,
  output logic                  rail_rst_n
);
  sq_state_t st_q, st_nx;
  logic [N_CH-1:0] ok_s;
  logic            all_off;
  logic            shut_entry;
  logic            in_run;
  logic            in_shut;
  logic            hold_cond;
  logic            hold_done;

  rail_seq_sync2 #(.W(N_CH)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_async(rail_ok), .q_sync(ok_s));

  assign all_off    = ~|gate_on;
  assign in_run     = (st_q == SQ_RUN);
  assign in_shut    = (st_q == SQ_SHUT);
  assign shut_entry = in_run && en_n;
  assign hold_cond  = in_run && !en_n && (&ok_s) && (&gate_full);

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      SQ_OFF:  if (!en_n)  st_nx = SQ_RUN;
      SQ_RUN:  if (en_n)   st_nx = SQ_SHUT;
      SQ_SHUT: if (all_off) st_nx = en_n ? SQ_OFF : SQ_PARK;
      SQ_PARK: if (en_n)   st_nx = SQ_OFF;
      default:             st_nx = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= SQ_OFF;
    else         st_q <= st_nx;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    rail_seq_chan #(.OFF_W(OFF_W)) u_chan (
      .clk(clk), .arst_n(arst_n),
      .on_req(in_run && !en_n && ok_s[i]),
      .load(shut_entry),
      .in_shut(in_shut),
      .dly(off_dly[i*OFF_W +: OFF_W]),
      .gate(gate_on[i]));

    AST_NO_DROP_WHILE_RUN: assert property (@(posedge clk) disable iff (!arst_n)
      $past(in_run) && $past(gate_on[i]) |-> gate_on[i]); // R3
  end

  rail_seq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .arst_n(arst_n), .cond(hold_cond), .done(hold_done));

  assign rail_rst_n = hold_done;

  AST_RST_LOW_IN_SHUT: assert property (@(posedge clk) disable iff (!arst_n)
    in_shut |-> !rail_rst_n); // R4
  AST_RST_NEEDS_FULL: assert property (@(posedge clk) disable iff (!arst_n)
    rail_rst_n |-> $past(&gate_full) && $past(&ok_s)); // R2
  AST_SHUT_NO_RISE: assert property (@(posedge clk) disable iff (!arst_n)
    $past(in_shut) |-> (gate_on & ~$past(gate_on)) == '0); // R6
  AST_RUN_FROM_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    in_run && !$past(in_run) |-> $past(st_q == SQ_OFF)); // R7
  AST_PARK_GATES_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == SQ_PARK) |-> all_off); // R7
endmodule

// File: tb/sim_rail_seq_top.sv
module sim_rail_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 4;
  localparam int OFF_W = 8;
  localparam int HOLD  = 20;
  localparam int NV    = 6;
  localparam logic [3:0] OK_V  [NV] = '{4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b1100, 4'b1111};
  localparam logic [3:0] EXP_V [NV] = '{4'b0001, 4'b0011, 4'b0011, 4'b0111, 4'b1111, 4'b1111};
  localparam int DLY [N_CH] = '{5, 2, 8, 0};

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic en_n = 1'b1;
  logic [N_CH-1:0] rail_ok = '0;
  logic [N_CH-1:0] gate_full = '0;
  logic [N_CH*OFF_W-1:0] off_dly;
  logic [N_CH-1:0] gate_on;
  logic rail_rst_n;
  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_seq_top #(.N_CH(N_CH), .OFF_W(OFF_W), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .arst_n(arst_n), .en_n(en_n), .rail_ok(rail_ok),
    .gate_full(gate_full), .off_dly(off_dly), .gate_on(gate_on),
    .rail_rst_n(rail_rst_n));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    logic [3:0] expg;
    for (int i = 0; i < N_CH; i++) off_dly[i*OFF_W +: OFF_W] = OFF_W'(DLY[i]);
    tick(3);
    chk("R8 gates in reset", 32'(gate_on), 0);
    chk("R8 rst in reset", 32'(rail_rst_n), 0);
    arst_n = 1'b1;
    tick(1);
    en_n = 1'b0;
    prev = '0;
    for (int k = 0; k < NV; k++) begin
      rail_ok = OK_V[k];
      tick(2);
      chk("R1 before latency", 32'(gate_on), 32'(prev));
      tick(1);
      chk("R1/R3 gate pattern", 32'(gate_on), 32'(EXP_V[k]));
      chk("R2 rst held low", 32'(rail_rst_n), 0);
      prev = EXP_V[k];
    end
    // R5: partial hold then a gate_full drop
    gate_full = 4'hF;
    tick(10);
    chk("R5 not yet released", 32'(rail_rst_n), 0);
    gate_full = 4'b1011;
    tick(1);
    gate_full = 4'hF;
    tick(HOLD-1);
    chk("R5 restarted count", 32'(rail_rst_n), 0);
    tick(1);
    chk("R2 released after hold", 32'(rail_rst_n), 1);
    // R3: rail drop pulls reset, gates stay
    rail_ok = 4'b1011;
    tick(2);
    chk("R3 sync latency", 32'(rail_rst_n), 1);
    tick(1);
    chk("R3 reset low", 32'(rail_rst_n), 0);
    chk("R3 gates kept", 32'(gate_on), 32'hF);
    rail_ok = 4'hF;
    tick(HOLD+3);
    chk("R2 re-release", 32'(rail_rst_n), 1);
    // R4/R6: timed power-down
    en_n = 1'b1;
    for (int t = 1; t <= 11; t++) begin
      tick(1);
      expg = '0;
      for (int i = 0; i < N_CH; i++) expg[i] = (t < DLY[i] + 2);
      chk("R4 off order", 32'(gate_on), 32'(expg));
      chk("R4 rst low", 32'(rail_rst_n), 0);
      if (t == 3) begin
        rail_ok = '0;
        en_n = 1'b0;
      end
    end
    tick(3);
    rail_ok = 4'hF;
    tick(5);
    chk("R7 parked, no restart", 32'(gate_on), 0);
    en_n = 1'b1;
    tick(2);
    en_n = 1'b0;
    tick(1);
    chk("R7 one edge into run", 32'(gate_on), 0);
    tick(1);
    chk("R7 gates back", 32'(gate_on), 32'hF);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule